// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block is the per-CPU register bank of an interrupt controller. A host addresses one register at a time with an index, a write strobe with write data, or a read strobe. Each register treats a write in its own way. Some keep only one field. One forces a field to ones. One cannot be written at all. Some hold read-only bits. The error status register needs two writes in a row before it actually clears.

Reads are combinational: the selected value appears on the read data bus in the same cycle as the read strobe. Writes take effect at the next rising clock edge. Two pieces of internal state are exported to the rest of the controller: the software-enable flag and the hidden flag of the error status register.

Indices that belong to features kept outside this bank return zero and raise an "unimplemented" flag. These are the priority arbitration, end-of-interrupt, command and per-vector array registers. Indices that map to nothing return zero and raise a separate "bad index" flag.

Top module: `intc_regbank`

## Requirements
- R1: After reset every register reads zero except the destination format register, which reads 0xFFFFFFFF. The software-enable output and the error flag output are 0.
- R2: A write to the ID register (index 0) or the task priority register (index 2) stores only data bits 7:0; every other bit reads zero.
- R3: A write to the logical destination register (index 6) stores only data bits 31:24; bits 23:0 read zero.
- R4: The destination format register (index 7) stores the write data ORed with 0x0FFFFFFF, so bits 27:0 always read one.
- R5: The version register (index 1) ignores every write and always reads the parameter VERSION_VALUE (default 0).
- R6: A write to the spurious vector register (index 8) stores the full data word and loads the software-enable output from data bit 8, visible from the next cycle. The focus warning output is high during that write cycle exactly when data bit 9 is set.
- R7: The error status register (index 9) has a hidden flag. A write while the flag is 0 sets the flag and leaves the register unchanged. A write while the flag is 1 clears the flag and writes the register to zero.
- R8: Any read of the error status register clears the hidden flag. When a read and a write to it arrive in the same cycle, the write is judged against the flag value from before the cycle, and the read's clear is applied last, so the flag ends at 0.
- R9: The six vector table entries (indices 16 to 21: timer, thermal, performance counter, local line 0, local line 1, error) keep bits 12 and 14 across writes and take all other bits from the data.
- R10: Read data equals the addressed register in the same cycle the read strobe is high, and is zero while the read strobe is low.
- R11: Indices 3, 4, 5, 10, 11 and 32 to 63 are unimplemented. An access to one of them returns zero, and the unimplemented output is high in that access cycle. A write to one of them changes no register.
- R12: Any other index (12 to 15, 22 to 31) returns zero, and the bad index output is high in that access cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_i | input | 6 | Register index |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid in the read-strobe cycle |
| unimpl_o | output | 1 | Access to an unimplemented index |
| bad_idx_o | output | 1 | Access to an unmapped index |
| focus_warn_o | output | 1 | Spurious-vector write requested focus checking |
| sw_enable_o | output | 1 | Software-enable flag |
| esr_flag_o | output | 1 | Hidden error status flag |

## Verification
Read data and the unimplemented, bad index and focus warning outputs are combinational, so they are due in the strobe cycle itself. The bench drives each access on the falling edge and samples these outputs 1 ns later, before the next rising edge. Register contents, the software-enable output and the error flag change at the rising edge that ends a write or read cycle. They are therefore checked with a read issued in a later cycle, or sampled after that edge. The same-cycle read-and-write case on the error status register is issued as a single strobe cycle from both flag states, and the flag is checked after it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 32;
  localparam int NUM_LVT = 6;

  localparam int IDX_ID         = 0;
  localparam int IDX_VER        = 1;
  localparam int IDX_TPR        = 2;
  localparam int IDX_ARB        = 3;
  localparam int IDX_PPR        = 4;
  localparam int IDX_EOI        = 5;
  localparam int IDX_LDR        = 6;
  localparam int IDX_DFR        = 7;
  localparam int IDX_SVR        = 8;
  localparam int IDX_ESR        = 9;
  localparam int IDX_CMD_LO     = 10;
  localparam int IDX_CMD_HI     = 11;
  localparam int IDX_LVT_BASE   = 16;
  localparam int IDX_ARRAY_BASE = 32;

  localparam int SVR_EN_BIT    = 8;
  localparam int SVR_FOCUS_BIT = 9;

  localparam logic [DATA_W-1:0] LVT_RO_MASK = DATA_W'((1 << 12) | (1 << 14));
  localparam logic [DATA_W-1:0] BYTE0_MASK  = DATA_W'(32'h0000_00FF);
  localparam logic [DATA_W-1:0] BYTE3_MASK  = DATA_W'(32'hFF00_0000);
  localparam logic [DATA_W-1:0] DFR_FORCE   = DATA_W'(32'h0FFF_FFFF);

  typedef struct packed {
    logic               id;
    logic               ver;
    logic               tpr;
    logic               ldr;
    logic               dfr;
    logic               svr;
    logic               esr;
    logic [NUM_LVT-1:0] lvt;
    logic               unimpl;
    logic               bad;
  } intc_sel_t;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output intc_sel_t        sel_o
);
  int idx_int;

  always_comb begin
    idx_int = int'(idx_i);
    sel_o   = '0;
    if (idx_int >= IDX_ARRAY_BASE) begin
      sel_o.unimpl = 1'b1;
    end else begin
      case (idx_int)
        IDX_ID:  sel_o.id  = 1'b1;
        IDX_VER: sel_o.ver = 1'b1;
        IDX_TPR: sel_o.tpr = 1'b1;
        IDX_LDR: sel_o.ldr = 1'b1;
        IDX_DFR: sel_o.dfr = 1'b1;
        IDX_SVR: sel_o.svr = 1'b1;
        IDX_ESR: sel_o.esr = 1'b1;
        IDX_ARB, IDX_PPR, IDX_EOI, IDX_CMD_LO, IDX_CMD_HI:
          sel_o.unimpl = 1'b1;
        default: begin
          for (int k = 0; k < NUM_LVT; k++) begin
            if (idx_int == IDX_LVT_BASE + k) sel_o.lvt[k] = 1'b1;
          end
          if (sel_o.lvt == '0) sel_o.bad = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int             W     = 32,
  parameter logic [W-1:0]   KEEP  = '1,
  parameter logic [W-1:0]   FORCE = '0,
  parameter logic [W-1:0]   RO    = '0,
  parameter logic [W-1:0]   RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we_i) q_nxt = (((d_i & KEEP) | FORCE) & ~RO) | (q & RO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST;
    else if (we_i) q <= q_nxt;
  end

  assign q_o = q;

  // R9: protected bits survive any write
  assert_ro_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ((q_o & RO) == $past(q_o & RO)));

  // R4: forced bits always read one
  assert_force_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_o & FORCE) == FORCE));

  // R2 / R3: bits outside the kept field stay at their reset value after a write
  assert_keep_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ((q_o & ~KEEP & ~FORCE & ~RO) == '0));
endmodule

// File: rtl/intc_esr_unit.sv
module intc_esr_unit
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit_i,
  input  logic              rd_hit_i,
  output logic              flag_o,
  output logic [DATA_W-1:0] val_o
);
  logic              flag_q, flag_nxt;
  logic [DATA_W-1:0] val_q, val_nxt;
  logic              flag_en, val_en;

  always_comb begin
    flag_nxt = flag_q;
    if (wr_hit_i) flag_nxt = ~flag_q;
    if (rd_hit_i) flag_nxt = 1'b0;
    flag_en  = wr_hit_i | rd_hit_i;
    val_en   = wr_hit_i & flag_q;
    val_nxt  = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_nxt;
  end

  assign flag_o = flag_q;
  assign val_o  = val_q;

  // R8: a read always leaves the flag clear
  assert_rd_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_i |=> !flag_o);

  // R7: first write arms the flag and leaves the value alone
  assert_first_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_i && !rd_hit_i && !flag_o) |=> (flag_o && $stable(val_o)));

  // R7: second write clears the value
  assert_second_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_i && flag_o) |=> (val_o == '0 && !flag_o));
endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
  import intc_pkg::*;
#(
  parameter logic [31:0] VERSION_VALUE = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       idx_i,
  input  logic [31:0]      wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [31:0]      rdata_o,
  output logic             unimpl_o,
  output logic             bad_idx_o,
  output logic             focus_warn_o,
  output logic             sw_enable_o,
  output logic             esr_flag_o
);
  intc_sel_t         sel;
  logic [DATA_W-1:0] id_q, tpr_q, ldr_q, dfr_q, svr_q, esr_q;
  logic [DATA_W-1:0] lvt_q [NUM_LVT];
  logic              swen_q, swen_nxt, swen_en;
  logic              access;
  logic [DATA_W-1:0] rd_mux;

  intc_decode u_decode (
    .idx_i (idx_i),
    .sel_o (sel)
  );

  intc_mask_reg #(.W(DATA_W), .KEEP(BYTE0_MASK)) u_id (
    .clk (clk), .rst_n (rst_n), .we_i (wr_i & sel.id), .d_i (wdata_i), .q_o (id_q)
  );

  intc_mask_reg #(.W(DATA_W), .KEEP(BYTE0_MASK)) u_tpr (
    .clk (clk), .rst_n (rst_n), .we_i (wr_i & sel.tpr), .d_i (wdata_i), .q_o (tpr_q)
  );

  intc_mask_reg #(.W(DATA_W), .KEEP(BYTE3_MASK)) u_ldr (
    .clk (clk), .rst_n (rst_n), .we_i (wr_i & sel.ldr), .d_i (wdata_i), .q_o (ldr_q)
  );

  intc_mask_reg #(.W(DATA_W), .FORCE(DFR_FORCE), .RST('1)) u_dfr (
    .clk (clk), .rst_n (rst_n), .we_i (wr_i & sel.dfr), .d_i (wdata_i), .q_o (dfr_q)
  );

  intc_mask_reg #(.W(DATA_W)) u_svr (
    .clk (clk), .rst_n (rst_n), .we_i (wr_i & sel.svr), .d_i (wdata_i), .q_o (svr_q)
  );

  for (genvar g = 0; g < NUM_LVT; g++) begin : g_lvt
    intc_mask_reg #(.W(DATA_W), .RO(LVT_RO_MASK)) u_lvt (
      .clk (clk), .rst_n (rst_n), .we_i (wr_i & sel.lvt[g]), .d_i (wdata_i),
      .q_o (lvt_q[g])
    );
  end

  intc_esr_unit u_esr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit_i (wr_i & sel.esr),
    .rd_hit_i (rd_i & sel.esr),
    .flag_o   (esr_flag_o),
    .val_o    (esr_q)
  );

  // software-enable flag: cleared then loaded from the spurious-vector write
  always_comb begin
    swen_en  = wr_i & sel.svr;
    swen_nxt = 1'b0;
    if (swen_en) swen_nxt = wdata_i[SVR_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       swen_q <= 1'b0;
    else if (swen_en) swen_q <= swen_nxt;
  end

  always_comb begin
    rd_mux = '0;
    if (sel.id)  rd_mux = id_q;
    if (sel.ver) rd_mux = VERSION_VALUE;
    if (sel.tpr) rd_mux = tpr_q;
    if (sel.ldr) rd_mux = ldr_q;
    if (sel.dfr) rd_mux = dfr_q;
    if (sel.svr) rd_mux = svr_q;
    if (sel.esr) rd_mux = esr_q;
    for (int k = 0; k < NUM_LVT; k++) begin
      if (sel.lvt[k]) rd_mux = lvt_q[k];
    end
  end

  assign access       = rd_i | wr_i;
  assign rdata_o      = rd_i ? rd_mux : '0;
  assign unimpl_o     = access & sel.unimpl;
  assign bad_idx_o    = access & sel.bad;
  assign focus_warn_o = wr_i & sel.svr & wdata_i[SVR_FOCUS_BIT];
  assign sw_enable_o  = swen_q;

  // R5: version reads its constant
  assert_version_const_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && idx_i == 6'(IDX_VER)) |-> (rdata_o == VERSION_VALUE));

  // R6: software enable follows bit 8 of the last spurious-vector write
  assert_swen_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && idx_i == 6'(IDX_SVR)) |=> (sw_enable_o == $past(wdata_i[SVR_EN_BIT])));

  // R6: warning only on a write
  assert_focus_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    focus_warn_o |-> wr_i);

  // R10: quiet bus without a read
  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |-> (rdata_o == '0));

  // R11: unimplemented index reads zero
  assert_unimpl_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_o |-> (rdata_o == '0 && !bad_idx_o));

  // R12: unmapped index reads zero
  assert_bad_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bad_idx_o |-> (rdata_o == '0));
endmodule

// File: tb/tb_intc_regbank.sv
`timescale 1ns/100ps
module tb_intc_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  idx;
  logic [31:0] wdata;
  logic        wr, rd;
  logic [31:0] rdata;
  logic        unimpl, bad, warn, swen, eflag;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  intc_regbank dut (
    .clk (clk), .rst_n (rst_n), .idx_i (idx), .wdata_i (wdata), .wr_i (wr),
    .rd_i (rd), .rdata_o (rdata), .unimpl_o (unimpl), .bad_idx_o (bad),
    .focus_warn_o (warn), .sw_enable_o (swen), .esr_flag_o (eflag)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] i, input logic [31:0] d,
                          output logic w);
    @(negedge clk);
    idx = i; wdata = d; wr = 1'b1;
    #1 w = warn;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] i, output logic [31:0] d,
                         output logic u, output logic b);
    @(negedge clk);
    idx = i; rd = 1'b1;
    #1 d = rdata; u = unimpl; b = bad;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_rdwr(input logic [5:0] i, input logic [31:0] d);
    @(negedge clk);
    idx = i; wdata = d; rd = 1'b1; wr = 1'b1;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic u, b;
    chk("R1", "sw_enable", {31'b0, swen}, 32'h0);
    chk("R1", "esr flag", {31'b0, eflag}, 32'h0);
    do_read(6'd0, d, u, b);  chk("R1", "ID reset", d, 32'h0);
    do_read(6'd7, d, u, b);  chk("R1", "DFR reset", d, 32'hFFFF_FFFF);
    do_read(6'd8, d, u, b);  chk("R1", "SVR reset", d, 32'h0);
    do_read(6'd16, d, u, b); chk("R1", "LVT0 reset", d, 32'h0);
  endtask

  task automatic t_byte_regs;
    logic [31:0] d; logic u, b, w;
    do_write(6'd0, 32'hFFFF_FFFF, w);
    do_read(6'd0, d, u, b); chk("R2", "ID masked", d, 32'h0000_00FF);
    do_write(6'd2, 32'h1234_5678, w);
    do_read(6'd2, d, u, b); chk("R2", "TPR masked", d, 32'h0000_0078);
    do_write(6'd6, 32'h1234_5678, w);
    do_read(6'd6, d, u, b); chk("R3", "LDR masked", d, 32'h1200_0000);
  endtask

  task automatic t_dfr_ver;
    logic [31:0] d; logic u, b, w;
    do_write(6'd7, 32'h0, w);
    do_read(6'd7, d, u, b); chk("R4", "DFR zero write", d, 32'h0FFF_FFFF);
    do_write(6'd7, 32'hA000_0000, w);
    do_read(6'd7, d, u, b); chk("R4", "DFR upper write", d, 32'hAFFF_FFFF);
    do_write(6'd1, 32'hFFFF_FFFF, w);
    do_read(6'd1, d, u, b); chk("R5", "version after write", d, 32'h0);
  endtask

  task automatic t_svr;
    logic [31:0] d; logic u, b, w;
    do_write(6'd8, 32'h0000_0100, w);
    chk("R6", "no focus warn", {31'b0, w}, 32'h0);
    chk("R6", "sw enable set", {31'b0, swen}, 32'h1);
    do_read(6'd8, d, u, b); chk("R6", "SVR stored", d, 32'h0000_0100);
    do_write(6'd8, 32'h0000_0200, w);
    chk("R6", "focus warn", {31'b0, w}, 32'h1);
    chk("R6", "sw enable cleared", {31'b0, swen}, 32'h0);
  endtask

  task automatic t_esr;
    logic [31:0] d; logic u, b, w;
    do_write(6'd9, 32'hDEAD_BEEF, w);
    chk("R7", "flag after first write", {31'b0, eflag}, 32'h1);
    do_write(6'd9, 32'hDEAD_BEEF, w);
    chk("R7", "flag after second write", {31'b0, eflag}, 32'h0);
    do_read(6'd9, d, u, b); chk("R7", "ESR value", d, 32'h0);
    do_write(6'd9, 32'h1, w);
    chk("R7", "flag rearmed", {31'b0, eflag}, 32'h1);
    do_read(6'd9, d, u, b);
    chk("R8", "read clears flag", {31'b0, eflag}, 32'h0);
    do_rdwr(6'd9, 32'h5);
    chk("R8", "rd+wr from clear flag", {31'b0, eflag}, 32'h0);
    do_write(6'd9, 32'h5, w);
    do_rdwr(6'd9, 32'h5);
    chk("R8", "rd+wr from set flag", {31'b0, eflag}, 32'h0);
  endtask

  task automatic t_lvt;
    logic [31:0] d; logic u, b, w;
    for (int k = 0; k < 6; k++) begin
      do_write(6'(16 + k), 32'hFFFF_FFFF, w);
      do_read(6'(16 + k), d, u, b); chk("R9", "LVT ro bits", d, 32'hFFFF_AFFF);
    end
    do_write(6'd21, 32'h0001_2345, w);
    do_read(6'd21, d, u, b); chk("R9", "LVT pattern", d, 32'h0001_2345 & ~32'h5000);
  endtask

  task automatic t_access_flags;
    logic [31:0] d; logic u, b, w;
    @(negedge clk); idx = 6'd0; rd = 1'b0;
    #1 chk("R10", "idle bus", rdata, 32'h0);
    do_read(6'd0, d, u, b); chk("R10", "same-cycle read", d, 32'h0000_00FF);
    do_read(6'd3, d, u, b);
    chk("R11", "unimpl data", d, 32'h0);
    chk("R11", "unimpl flag", {30'b0, u, b}, 32'h2);
    do_write(6'd40, 32'h1234_5678, w);
    do_read(6'd40, d, u, b);
    chk("R11", "array idx", {d[29:0], u, b}, 32'h2);
    do_read(6'd0, d, u, b); chk("R11", "ID untouched", d, 32'h0000_00FF);
    do_read(6'd13, d, u, b);
    chk("R12", "bad idx 13", {d[29:0], u, b}, 32'h1);
    do_read(6'd22, d, u, b);
    chk("R12", "bad idx 22", {d[29:0], u, b}, 32'h1);
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idx = '0; wdata = '0; wr = 1'b0; rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_byte_regs();
    t_dfr_ver();
    t_svr();
    t_esr();
    t_lvt();
    t_access_flags();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule